// File: doc/BRIEF.md
# Channel-Sweep Sample FIFO with Threshold Interrupt

This block sits between a 12-bit converter and a host. A small sequencer tells the converter which of eight input channels to sample next. In fixed mode it holds one programmed channel. In sweep mode it steps through a programmed list of up to eight channel numbers and wraps back to the start of the list.

Each finished conversion arrives as a one-cycle valid strobe with 12-bit data. It is written into an eight-entry FIFO, tagged with the channel that produced it, so the host can confirm the ordering.

A fill threshold is chosen in quarter-depth steps. An interrupt goes high as soon as the stored count reaches that threshold, and the host drains results with a read strobe. Two sticky flags record a write that was lost because the FIFO was full and a read attempted while it was empty.

Top module: `sweep_sample_fifo`

## Requirements
- R1: Results leave in the order they arrived, each with its 12-bit data and 3-bit channel tag. `rd_data` and `rd_ch` are valid in the cycle after the clock edge that samples `rd_en` high on a non-empty FIFO.
- R2: With `cfg_sweep_en` = 0, `conv_ch` equals `cfg_fixed_ch`, and conversions do not move the sweep position.
- R3: With `cfg_sweep_en` = 1, `conv_ch` is the list entry at the current position. Entry i sits in bits [3i+2:3i] of `cfg_sweep_list`. Each `conv_valid` moves the position by one, and it returns to 0 after position `cfg_sweep_len`, which is the list length minus one.
- R4: `cfg_thresh` codes 0, 1, 2 and 3 select thresholds of 2, 4, 6 and 8 entries. `irq` rises together with `fill` on the edge where an accepted write brings the count up to the threshold.
- R5: Once high, `irq` stays high until `fill` falls below the threshold or `irq_clr` is pulsed, and the clear wins. After a clear, `irq` rises again only on a fresh upward crossing.
- R6: A conversion arriving while `fill` is 8 is dropped, leaves `fill` at 8, and sets `ovf`, which stays set until reset.
- R7: A read while `fill` is 0 leaves `rd_data`, `rd_ch` and `fill` unchanged and sets `unf`, which stays set until reset.
- R8: A synchronous active-high `rst` empties the FIFO and sets the sweep position to 0. It also clears `irq`, `ovf` and `unf`, and zeroes `rd_data` and `rd_ch`.
- R9: `fill` reports the stored count. It never exceeds 8, and a read and a write accepted in the same cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sweep_en | input | 1 | 1 = sweep list, 0 = fixed channel |
| cfg_fixed_ch | input | 3 | Channel used in fixed mode |
| cfg_sweep_list | input | 24 | Eight 3-bit channel numbers, entry i at [3i+2:3i] |
| cfg_sweep_len | input | 3 | Last used list position (length minus one) |
| cfg_thresh | input | 2 | Threshold code: 2, 4, 6 or 8 entries |
| conv_ch | output | 3 | Channel to convert next |
| conv_valid | input | 1 | Conversion result strobe |
| conv_data | input | 12 | Conversion result |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 12 | Oldest result popped by the last read |
| rd_ch | output | 3 | Channel tag of that result |
| fill | output | 4 | Stored entry count |
| irq | output | 1 | Threshold interrupt |
| irq_clr | input | 1 | Interrupt clear pulse |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The main function is exercised three ways.

- A four-channel sweep with a wrap separates a correct list position from an off-by-one in the wrap compare.
- A fixed-channel run of eight samples followed by a ninth tells an accepted write from a dropped one. Switching back to sweep then shows that the position held still.
- Quarter, half, three-quarter and full thresholds are each crossed. Together with a clear, a drain below the level and a refill, these separate a level-held interrupt from an edge-armed one.

Same-cycle read and write, an empty read and a mid-run reset cover the count arithmetic and the restart.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    localparam int CH_W   = 3;
    localparam int DATA_W = 12;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] data;
    } sample_t;
endpackage

// File: rtl/sweep_seq.sv
module sweep_seq import sweep_pkg::*; #(
    parameter int LIST_N = 8,
    localparam int IW = $clog2(LIST_N)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sweep_en,
    input  logic [CH_W-1:0]          fixed_ch,
    input  logic [LIST_N*CH_W-1:0]   list,
    input  logic [IW-1:0]            last_pos,
    input  logic                     step,
    output logic [CH_W-1:0]          ch
);
    typedef struct packed {
        logic [IW-1:0] pos;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step && sweep_en) begin
            s_d.pos = (s_q.pos >= last_pos) ? '0 : s_q.pos + 1'b1;
        end
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ch = sweep_en ? list[s_q.pos*CH_W +: CH_W] : fixed_ch;
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo import sweep_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  sample_t       wr_item,
    input  logic          rd_en,
    output sample_t       rd_item,
    output logic [CW-1:0] count_q,
    output logic [CW-1:0] count_d,
    output logic          ovf,
    output logic          unf
);
    typedef struct packed {
        sample_t [DEPTH-1:0] mem;
        logic [AW-1:0]       wptr;
        logic [AW-1:0]       rptr;
        logic [CW-1:0]       cnt;
        sample_t             rd;
        logic                ovf;
        logic                unf;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic do_wr, do_rd;

    always_comb begin
        s_d   = s_q;
        do_wr = wr_en && (s_q.cnt != CW'(DEPTH));
        do_rd = rd_en && (s_q.cnt != '0);
        if (wr_en && !do_wr) s_d.ovf = 1'b1;
        if (rd_en && !do_rd) s_d.unf = 1'b1;
        if (do_wr) begin
            s_d.mem[s_q.wptr] = wr_item;
            s_d.wptr = (s_q.wptr == AW'(DEPTH-1)) ? '0 : s_q.wptr + 1'b1;
        end
        if (do_rd) begin
            s_d.rd   = s_q.mem[s_q.rptr];
            s_d.rptr = (s_q.rptr == AW'(DEPTH-1)) ? '0 : s_q.rptr + 1'b1;
        end
        s_d.cnt = s_q.cnt + CW'(do_wr) - CW'(do_rd);
        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign rd_item = s_q.rd;
    assign count_q = s_q.cnt;
    assign count_d = s_d.cnt;
    assign ovf     = s_q.ovf;
    assign unf     = s_q.unf;
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int QTR = DEPTH / 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    level,
    input  logic [CW-1:0] count_q,
    input  logic [CW-1:0] count_d,
    input  logic          clr,
    output logic          irq
);
    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t    s_d, s_q;
    logic [CW-1:0] thr;

    always_comb begin
        thr = CW'((int'(level) + 1) * QTR);
        s_d = s_q;
        if (count_d < thr) begin
            s_d.irq = 1'b0;
        end else if (count_q < thr) begin
            s_d.irq = 1'b1;
        end
        if (clr || rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign irq = s_q.irq;
endmodule

// File: rtl/sweep_sample_fifo.sv
module sweep_sample_fifo import sweep_pkg::*; #(
    parameter int DEPTH  = 8,
    parameter int LIST_N = 8,
    localparam int CW = $clog2(DEPTH) + 1,
    localparam int IW = $clog2(LIST_N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_sweep_en,
    input  logic [CH_W-1:0]        cfg_fixed_ch,
    input  logic [LIST_N*CH_W-1:0] cfg_sweep_list,
    input  logic [IW-1:0]          cfg_sweep_len,
    input  logic [1:0]             cfg_thresh,
    output logic [CH_W-1:0]        conv_ch,
    input  logic                   conv_valid,
    input  logic [DATA_W-1:0]      conv_data,
    input  logic                   rd_en,
    output logic [DATA_W-1:0]      rd_data,
    output logic [CH_W-1:0]        rd_ch,
    output logic [CW-1:0]          fill,
    output logic                   irq,
    input  logic                   irq_clr,
    output logic                   ovf,
    output logic                   unf
);
    sample_t       wr_item, rd_item;
    logic [CW-1:0] cnt_d;

    sweep_seq #(.LIST_N(LIST_N)) u_seq (
        .clk(clk), .rst(rst), .sweep_en(cfg_sweep_en), .fixed_ch(cfg_fixed_ch),
        .list(cfg_sweep_list), .last_pos(cfg_sweep_len), .step(conv_valid),
        .ch(conv_ch)
    );

    assign wr_item = '{ch: conv_ch, data: conv_data};

    sample_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(conv_valid), .wr_item(wr_item),
        .rd_en(rd_en), .rd_item(rd_item), .count_q(fill), .count_d(cnt_d),
        .ovf(ovf), .unf(unf)
    );

    irq_gen #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst(rst), .level(cfg_thresh), .count_q(fill),
        .count_d(cnt_d), .clr(irq_clr), .irq(irq)
    );

    assign rd_data = rd_item.data;
    assign rd_ch   = rd_item.ch;
endmodule

// File: rtl/sweep_fifo_checks.sv
module sweep_fifo_checks #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cfg_thresh,
    input logic          conv_valid,
    input logic          rd_en,
    input logic [11:0]   rd_data,
    input logic [2:0]    rd_ch,
    input logic [CW-1:0] fill,
    input logic          irq,
    input logic          irq_clr,
    input logic          ovf,
    input logic          unf
);
    logic [CW-1:0] thr_prev;

    always_ff @(posedge clk) begin
        thr_prev <= CW'((int'(cfg_thresh) + 1) * (DEPTH / 4));
    end

    a_r8_reset: assert property (@(posedge clk)
        rst |=> (fill == '0 && !irq && !ovf && !unf));
    a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && !rd_en && fill == CW'(DEPTH)) |=> (fill == CW'(DEPTH) && ovf));
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        unf |=> unf);
    a_r7_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fill == '0) |=> (unf && $stable(rd_data) && $stable(rd_ch)));
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> !irq);
    a_r5_below: assert property (@(posedge clk) disable iff (rst)
        irq |-> (fill >= thr_prev));
    a_r4_rise_at_level: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (fill == thr_prev));
    a_r9_fill_max: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));
endmodule

bind sweep_sample_fifo sweep_fifo_checks #(.DEPTH(DEPTH)) u_checks (
    .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh), .conv_valid(conv_valid),
    .rd_en(rd_en), .rd_data(rd_data), .rd_ch(rd_ch), .fill(fill), .irq(irq),
    .irq_clr(irq_clr), .ovf(ovf), .unf(unf)
);

// File: tb/test_sweep_sample_fifo.sv
`timescale 1ns/1ps
module test_sweep_sample_fifo;
    import sweep_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_sweep_en = 1'b1;
    logic [2:0]  cfg_fixed_ch = 3'd3;
    logic [23:0] cfg_sweep_list = {3'd7, 3'd5, 3'd3, 3'd1, 3'd6, 3'd4, 3'd2, 3'd0};
    logic [2:0]  cfg_sweep_len = 3'd3;
    logic [1:0]  cfg_thresh = 2'd1;
    logic [2:0]  conv_ch;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic [2:0]  rd_ch;
    logic [3:0]  fill;
    logic        irq;
    logic        irq_clr = 1'b0;
    logic        ovf, unf;

    sweep_sample_fifo i_sweep_sample_fifo (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    sample_t exp_q[$];
    sample_t last_out = '0;
    int mcount = 0, midx = 0;
    bit rd_was_empty;
    event rd_done;

    function automatic logic [2:0] list_at(int i);
        return cfg_sweep_list[i*3 +: 3];
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // driver: one conversion result, expected item pushed to the scoreboard
    task automatic conv(input logic [11:0] d);
        logic [2:0] ech;
        @(negedge clk);
        ech = cfg_sweep_en ? list_at(midx) : cfg_fixed_ch;
        check(cfg_sweep_en ? "R3 conv_ch" : "R2 conv_ch", conv_ch, ech);
        conv_valid = 1'b1;
        conv_data  = d;
        if (mcount < 8) begin
            exp_q.push_back('{ch: ech, data: d});
            mcount++;
        end
        if (cfg_sweep_en) midx = (midx >= int'(cfg_sweep_len)) ? 0 : midx + 1;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic rd();
        bit empty_now;
        @(negedge clk);
        empty_now = (mcount == 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (!empty_now) mcount--;
        rd_was_empty = empty_now;
        -> rd_done;
    endtask

    // monitor: compare each read against the scoreboard
    always @(rd_done) begin
        if (rd_was_empty) begin
            check("R7 held data", rd_data, last_out.data);
            check("R7 held tag", rd_ch, last_out.ch);
            check("R7 unf", unf, 1);
        end else begin
            sample_t e;
            e = exp_q.pop_front();
            check("R1 data", rd_data, e.data);
            check("R1 tag", rd_ch, e.ch);
            last_out = e;
        end
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8 fill", fill, 0);
        check("R8 irq", irq, 0);
        check("R8 ovf", ovf, 0);
        check("R8 unf", unf, 0);
        check("R8 start ch", conv_ch, 0);

        // sweep 0-2-4-6, half threshold
        conv(12'h100); conv(12'h101); conv(12'h102);
        check("R4 below half", irq, 0);
        check("R9 fill", fill, 3);
        conv(12'h103);
        check("R4 half reached", irq, 1);
        conv(12'h104);              // wraps to channel 0
        check("R3 wrap fill", fill, 5);
        rd();
        check("R5 held at level", irq, 1);
        rd();
        check("R5 drop below", irq, 0);
        rd(); rd(); rd();
        check("R9 drained", fill, 0);

        // empty read
        rd();
        check("R7 fill stays", fill, 0);

        // fixed channel 3, full threshold, overflow
        cfg_sweep_en = 1'b0;
        cfg_thresh   = 2'd3;
        for (int i = 0; i < 7; i++) conv(12'h300 + 12'(i));
        check("R4 below full", irq, 0);
        conv(12'h307);
        check("R4 full reached", irq, 1);
        conv(12'hBAD);
        check("R6 fill held", fill, 8);
        check("R6 ovf", ovf, 1);
        cfg_sweep_en = 1'b1;
        @(negedge clk);
        check("R2 position held", conv_ch, list_at(midx));
        rd();
        check("R5 full drop", irq, 0);
        for (int i = 0; i < 7; i++) rd();

        // quarter threshold, clear and re-arm
        cfg_thresh = 2'd0;
        conv(12'h400);
        check("R4 below quarter", irq, 0);
        conv(12'h401);
        check("R4 quarter reached", irq, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R5 cleared", irq, 0);
        check("R5 clear keeps data", fill, 2);
        conv(12'h402);
        check("R5 no re-raise above level", irq, 0);
        rd(); rd();
        conv(12'h403);
        check("R5 re-armed crossing", irq, 1);

        // three-quarter threshold
        cfg_thresh = 2'd2;
        @(negedge clk); @(negedge clk);
        check("R5 level raised", irq, 0);
        conv(12'h500); conv(12'h501); conv(12'h502);
        check("R4 below 3/4", irq, 0);
        conv(12'h503);
        check("R4 3/4 reached", irq, 1);

        // same-cycle read and write
        fork
            conv(12'h600);
            rd();
        join
        check("R9 rd+wr fill", fill, 6);
        check("R9 rd+wr irq", irq, 1);

        // reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_q.delete();
        mcount = 0; midx = 0; last_out = '0;
        check("R8 fill", fill, 0);
        check("R8 irq", irq, 0);
        check("R8 ovf", ovf, 0);
        check("R8 rd_data", rd_data, 0);
        check("R8 sweep restart", conv_ch, 0);
        conv(12'h700);
        rd();

        @(negedge clk);
        finish_run();
    end
endmodule